// File: doc/BRIEF.md
# Two-Plane Blink and Shutdown Controller

This block keeps the configuration register of a multiplexed character display and turns it into the control signals that the rest of the display path uses. Software writes the register through a simple port with address, data and strobe. The block then reports which of two character data planes is shown, whether the display is blanked, whether the display test is forcing every segment on, and single-cycle pulses that clear digit data and restart blink timing.

Blinking switches the shown data between two full planes. It does not gate the output on and off. To make a character flash, the other plane holds the blank character code 0x20. A free-running counter driven by the multiplex tick sets the blink period. A register bit chooses a fast or a slow period for the whole display. Once blinking is enabled it carries on with no further writes.

At power-up the register is all zeros. The display is therefore in shutdown and blanked, blinking is off, and plane P0 is shown.

Top module: `blink_shutdown_ctrl`

## Requirements
- R1: After reset, blankOut is 1, planeSel is 0 (plane P0), and clearDigits and blinkResync are both 0.
- R2: A write with wrEn=1 and wrAddr equal to CFG_ADDR (default 4) loads the register. Its bit 0 is the run bit (1 = normal, 0 = shutdown), bit 2 selects fast blink, and bit 3 enables blinking. Writes to any other address leave all outputs unchanged.
- R3: blankOut is 1 exactly when the run bit is 0 and dispTest is 0. Writes are accepted while the display is in shutdown.
- R4: With dispTest=1, allOn is 1 and blankOut is 0 whatever the run bit holds.
- R5: While the blink enable bit is 0, planeSel stays at 0 no matter how many multiplex ticks arrive.
- R6: With blinking enabled and the fast bit at 0, planeSel toggles once every 2^BLINK_K multiplex ticks (16 by default).
- R7: With blinking enabled and the fast bit at 1, planeSel toggles once every 2^(BLINK_K-1) multiplex ticks (8 by default).
- R8: Writing 1 to bit 4 raises blinkResync for exactly one cycle, starting the cycle after the write. On the cycle after that, the blink counter is zero and planeSel is 0, so the next toggle comes a full period later.
- R9: Writing 1 to bit 5 raises clearDigits for exactly one cycle, starting the cycle after the write. Bits 4 and 5 clear themselves and never stay set.
- R10: Once enabled, plane alternation keeps going across many periods with no further writes, and planeSel changes only on cycles that carry a multiplex tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 8 | Register write data |
| muxTick | input | 1 | One-cycle multiplex clock tick |
| dispTest | input | 1 | Display-test request |
| planeSel | output | 1 | Data plane shown now (0 = P0, 1 = P1) |
| blankOut | output | 1 | Display blanked (shutdown) |
| allOn | output | 1 | All segments forced on |
| clearDigits | output | 1 | One-cycle pulse to clear digit data |
| blinkResync | output | 1 | One-cycle pulse marking a blink timing restart |

## Verification
The plane select is driven with tick counts that stop just short of a period, land exactly on a period, and run past several periods. This separates an off-by-one divider from a correct one, and shows that alternation continues on its own. The same counts are repeated under fast blink, with blinking disabled, and in shutdown. These runs tell the two divide ratios apart and show that blanking and plane selection are independent. A resynchronisation issued mid-period checks that the next toggle comes a full period later. A write to a wrong address and a display-test request made while in shutdown check that decoding and the override hold.

// File: rtl/blink_ctrl_pkg.sv
`timescale 1ns/1ps
package blink_ctrl_pkg;
  localparam int CFG_W      = 8;
  localparam int RUN_BIT    = 0;
  localparam int FAST_BIT   = 2;
  localparam int BLINK_BIT  = 3;
  localparam int RESYNC_BIT = 4;
  localparam int CLEAR_BIT  = 5;

  // Strobes from the register control to the blink datapath
  typedef struct packed {
    logic runN;       // 1 = normal operation
    logic fastBlink;
    logic blinkEn;
    logic resync;     // single-cycle
    logic clearDigits;// single-cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/blink_cfg_ctrl.sv
`timescale 1ns/1ps
module blink_cfg_ctrl
  import blink_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CFG_W-1:0]    wrData,
  output ctrlStrobes_t        strobes
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);

  logic cfgHit;
  logic runR, fastR, blinkR, resyncR, clearR;

  assign cfgHit = wrEn && (wrAddr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR    <= 1'b0;
      fastR   <= 1'b0;
      blinkR  <= 1'b0;
      resyncR <= 1'b0;
      clearR  <= 1'b0;
    end else begin
      resyncR <= cfgHit && wrData[RESYNC_BIT];
      clearR  <= cfgHit && wrData[CLEAR_BIT];
      if (cfgHit) begin
        runR   <= wrData[RUN_BIT];
        fastR  <= wrData[FAST_BIT];
        blinkR <= wrData[BLINK_BIT];
      end
    end
  end

  always_comb begin
    strobes.runN        = runR;
    strobes.fastBlink   = fastR;
    strobes.blinkEn     = blinkR;
    strobes.resync      = resyncR;
    strobes.clearDigits = clearR;
  end

  AST_CLEAR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHit && wrData[CLEAR_BIT]) |=> strobes.clearDigits); // R9
  AST_CLEAR_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearDigits && !cfgHit) |=> !strobes.clearDigits); // R9
  AST_RESYNC_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resync && !cfgHit) |=> !strobes.resync); // R8
  AST_MISS_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !cfgHit |=> $stable(strobes.runN)); // R2
endmodule

// File: rtl/blink_plane_dp.sv
`timescale 1ns/1ps
module blink_plane_dp
  import blink_ctrl_pkg::*;
#(
  parameter int BLINK_K = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         muxTick,
  output logic         planeSel
);
  localparam logic [BLINK_K-1:0] SLOW_LIM = '1;
  localparam logic [BLINK_K-1:0] FAST_LIM = SLOW_LIM >> 1;

  logic [BLINK_K-1:0] cnt;
  logic [BLINK_K-1:0] lim;
  logic               plane;

  assign lim = strobes.fastBlink ? FAST_LIM : SLOW_LIM;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      plane <= 1'b0;
    end else if (strobes.resync || !strobes.blinkEn) begin
      cnt   <= '0;
      plane <= 1'b0;
    end else if (muxTick) begin
      if (cnt >= lim) begin
        cnt   <= '0;
        plane <= ~plane;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign planeSel = plane;

  AST_RESYNC_TO_P0: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resync |=> (planeSel == 1'b0 && cnt == '0)); // R8
  AST_IDLE_SHOWS_P0: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.blinkEn |=> (planeSel == 1'b0)); // R5
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!muxTick && strobes.blinkEn && !strobes.resync) |=> $stable(planeSel)); // R10
endmodule

// File: rtl/blink_shutdown_ctrl.sv
`timescale 1ns/1ps
module blink_shutdown_ctrl
  import blink_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 4,
  parameter int BLINK_K  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              muxTick,
  input  logic              dispTest,
  output logic              planeSel,
  output logic              blankOut,
  output logic              allOn,
  output logic              clearDigits,
  output logic              blinkResync
);
  ctrlStrobes_t strobes;

  blink_cfg_ctrl #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobes(strobes)
  );

  blink_plane_dp #(.BLINK_K(BLINK_K)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .muxTick(muxTick), .planeSel(planeSel)
  );

  assign allOn       = dispTest;
  assign blankOut    = !strobes.runN && !dispTest;
  assign clearDigits = strobes.clearDigits;
  assign blinkResync = strobes.resync;

  AST_TEST_UNBLANKS: assert property (@(posedge clk) disable iff (!rstN)
    dispTest |-> (allOn && !blankOut)); // R4
  AST_RUN_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runN |-> !blankOut); // R3
endmodule

// File: tb/blink_shutdown_ctrl_tb.sv
`timescale 1ns/1ps
module blink_shutdown_ctrl_tb_top;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] CFG = 4'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic muxTick = 1'b0;
  logic dispTest = 1'b0;
  logic planeSel, blankOut, allOn, clearDigits, blinkResync;

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  blink_shutdown_ctrl #(.ADDR_W(ADDR_W), .CFG_ADDR(4), .BLINK_K(4)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .muxTick(muxTick), .dispTest(dispTest), .planeSel(planeSel),
    .blankOut(blankOut), .allOn(allOn), .clearDigits(clearDigits),
    .blinkResync(blinkResync)
  );

  // {data[17:10], ticks[9:2], expPlane[1], expBlank[0]}
  localparam logic [17:0] VEC [8] = '{
    {8'h19, 8'd15, 1'b0, 1'b0},  // R6 one short of slow period
    {8'h19, 8'd16, 1'b1, 1'b0},  // R6 exactly one slow period
    {8'h19, 8'd40, 1'b0, 1'b0},  // R10 several periods
    {8'h1D, 8'd7,  1'b0, 1'b0},  // R7 one short of fast period
    {8'h1D, 8'd8,  1'b1, 1'b0},  // R7 exactly one fast period
    {8'h1D, 8'd24, 1'b1, 1'b0},  // R7 three fast periods
    {8'h11, 8'd40, 1'b0, 1'b0},  // R5 blink disabled
    {8'h18, 8'd16, 1'b1, 1'b1}   // R3 shutdown, still blinking
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); muxTick = 1'b1;
      @(negedge clk); muxTick = 1'b0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 blank", 8'(blankOut), 8'd1);
    chk("R1 plane", 8'(planeSel), 8'd0);
    chk("R1 clear", 8'(clearDigits), 8'd0);
    chk("R1 resync", 8'(blinkResync), 8'd0);

    for (int v = 0; v < 8; v++) begin
      wrReg(CFG, VEC[v][17:10]);
      ticks(int'(VEC[v][9:2]));
      chk($sformatf("R6/R7/R5/R10 vec%0d plane", v), 8'(planeSel), 8'(VEC[v][1]));
      chk($sformatf("R3 vec%0d blank", v), 8'(blankOut), 8'(VEC[v][0]));
    end

    // R3: write accepted in shutdown, then leave shutdown
    wrReg(CFG, 8'h01);
    chk("R3 leave shutdown", 8'(blankOut), 8'd0);
    // R2: miss address has no effect
    wrReg(4'd5, 8'h00);
    chk("R2 wrong address", 8'(blankOut), 8'd0);

    // R4: display test overrides shutdown
    wrReg(CFG, 8'h00);
    chk("R3 shutdown blank", 8'(blankOut), 8'd1);
    dispTest = 1'b1; #1;
    chk("R4 allOn", 8'(allOn), 8'd1);
    chk("R4 unblank", 8'(blankOut), 8'd0);
    dispTest = 1'b0; #1;
    chk("R3 blank back", 8'(blankOut), 8'd1);

    // R9: clear pulse
    @(negedge clk); wrEn = 1'b1; wrAddr = CFG; wrData = 8'h21;
    @(negedge clk); wrEn = 1'b0;
    chk("R9 clear high", 8'(clearDigits), 8'd1);
    @(negedge clk);
    chk("R9 clear self-clears", 8'(clearDigits), 8'd0);

    // R8: resync mid-period
    wrReg(CFG, 8'h19);
    ticks(20);
    chk("R8 before resync plane", 8'(planeSel), 8'd1);
    @(negedge clk); wrEn = 1'b1; wrAddr = CFG; wrData = 8'h19;
    @(negedge clk); wrEn = 1'b0;
    chk("R8 resync pulse", 8'(blinkResync), 8'd1);
    @(negedge clk);
    chk("R8 resync low", 8'(blinkResync), 8'd0);
    chk("R8 plane forced P0", 8'(planeSel), 8'd0);
    ticks(15);
    chk("R8 full period pending", 8'(planeSel), 8'd0);
    ticks(1);
    chk("R8 toggle after full period", 8'(planeSel), 8'd1);

    finishRun();
  end
endmodule